// File: doc/BRIEF.md
# Decimal Address Relocation and Bounds Checker

This block turns a six-digit decimal relative address into an absolute address in digit units. It adds a base register to the relative address. It can also add one of three index registers, each of which carries a sign. All of this arithmetic is done in BCD, so every digit stays a decimal digit from input to output. The absolute address names one 4-bit digit in memory.

Memory is arranged as four-digit words. The block therefore also gives the binary word address and the position of the digit inside that word. It raises a single address-error flag when any of these holds:

- the result leaves the window set by the base and limit registers;
- the access size needs alignment that the address does not have;
- an operand holds a nibble that is not a decimal digit;
- the arithmetic runs past six digits or goes below zero.

A request is given as one pulse of `req_valid`. The result appears with `out_valid` one cycle later, and it then holds until the next request.

Top module: `dec_addr_reloc`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `out_valid` is 0 and `abs_addr` is 0.
- R2: When `idx_sel` is 0, `abs_addr` is the decimal sum of `base_reg` and `rel_addr`. Each value is six BCD digits, with the most significant digit in bits [23:20].
- R3: When `idx_sel` = k (1 to 3) and `idx_neg[k-1]` is 0, the magnitude in `idx_mag[24k-1:24(k-1)]` is added in decimal as well.
- R4: When `idx_sel` = k and `idx_neg[k-1]` is 1, that magnitude is subtracted in decimal instead.
- R5: `addr_err` is 1 whenever the result is below `base_reg` or above `limit_reg`. Both bounds are inclusive.
- R6: Alignment depends on `acc_size`. A digit access (0) may use any address. A byte access (1) needs an even address. A word access (2) needs an address that is 0 modulo 4. Code 3 is always an error.
- R7: `word_addr` equals the absolute address divided by 4, and `digit_lane` equals the absolute address modulo 4, both in binary.
- R8: A nibble above 9 in `rel_addr`, `base_reg`, `limit_reg` or the selected index raises `addr_err`. The index registers that are not selected have no effect.
- R9: `addr_err` is 1 in two more cases: when base plus relative address exceeds 999999, and when adding or subtracting the index takes the result past 999999 or below 0.
- R10: `out_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. All outputs hold their values when no request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| rel_addr | input | 24 | Relative address, six BCD digits |
| idx_sel | input | 2 | 0 = no index, 1 to 3 = index register |
| acc_size | input | 2 | 0 = digit, 1 = byte, 2 = word, 3 = illegal |
| base_reg | input | 24 | Base register, six BCD digits |
| limit_reg | input | 24 | Upper bound, six BCD digits |
| idx_mag | input | 72 | Three index magnitudes, 24 bits each |
| idx_neg | input | 3 | Sign bit per index register, 1 = negative |
| out_valid | output | 1 | Result valid |
| abs_addr | output | 24 | Absolute digit address, BCD |
| word_addr | output | 18 | Word address in binary |
| digit_lane | output | 2 | Digit position within the word |
| addr_err | output | 1 | Address error |

## Verification
The main sweep runs relative addresses across three base and limit windows. Each point is tried with no index, with each index register positive, and with each index register negative, under all four size codes.

- The unindexed cases check plain decimal carry propagation.
- The signed cases tell addition apart from ten's-complement subtraction.
- The window with base 0 drives negative indices below zero.
- The size codes separate the odd, even and modulo-four address classes.

Directed cases cover the remaining edges: an address exactly at the base or the limit and one digit past it, a bad nibble in each operand, a corrupt index register that is not selected, and a carry out of the sixth digit.

// File: rtl/dec_addr_reloc.sv
module dec_addr_reloc #(
  parameter int NDIG = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [4*NDIG-1:0]              rel_addr,
  input  logic [1:0]                     idx_sel,
  input  logic [1:0]                     acc_size,
  input  logic [4*NDIG-1:0]              base_reg,
  input  logic [4*NDIG-1:0]              limit_reg,
  input  logic [3*4*NDIG-1:0]            idx_mag,
  input  logic [2:0]                     idx_neg,
  output logic                           out_valid,
  output logic [4*NDIG-1:0]              abs_addr,
  output logic [$clog2(10**NDIG)-3:0]    word_addr,
  output logic [1:0]                     digit_lane,
  output logic                           addr_err
);

  localparam int AW = 4 * NDIG;
  localparam int BW = $clog2(10**NDIG);

  function automatic logic digits_ok(input logic [AW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG; i++)
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [AW:0] bcd_add(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                          input logic cin);
    logic [AW-1:0] r;
    logic [4:0]    s;
    logic          c;
    c = cin;
    r = '0;
    for (int i = 0; i < NDIG; i++) begin
      s = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, c};
      if (s > 5'd9) begin
        s = s + 5'd6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      r[4*i +: 4] = s[3:0];
    end
    return {c, r};
  endfunction

  function automatic logic [AW-1:0] nines(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < NDIG; i++) r[4*i +: 4] = 4'd9 - v[4*i +: 4];
    return r;
  endfunction

  function automatic logic [BW-1:0] to_bin(input logic [AW-1:0] v);
    logic [BW-1:0] acc;
    acc = '0;
    for (int i = NDIG - 1; i >= 0; i--)
      acc = acc * BW'(10) + BW'(v[4*i +: 4]);
    return acc;
  endfunction

  logic [AW-1:0] idx_v, term, s1, s2;
  logic          idx_use, neg, c1, c2;
  logic [BW-1:0] bin;
  logic          ovf, bad_digit, out_of_win, misalign, err_now;

  always_comb begin
    idx_v = '0;
    neg   = 1'b0;
    for (int k = 0; k < 3; k++)
      if (idx_sel == 2'(k + 1)) begin
        idx_v = idx_mag[k*AW +: AW];
        neg   = idx_neg[k];
      end
  end

  assign idx_use = (idx_sel != 2'd0);
  assign term    = !idx_use ? '0 : (neg ? nines(idx_v) : idx_v);

  assign {c1, s1} = bcd_add(base_reg, rel_addr, 1'b0);
  assign {c2, s2} = bcd_add(s1, term, neg);

  assign ovf        = c1 | (idx_use & ~neg & c2) | (neg & ~c2);
  assign bad_digit  = ~(digits_ok(rel_addr) & digits_ok(base_reg) & digits_ok(limit_reg)
                        & (~idx_use | digits_ok(idx_v)));
  assign out_of_win = (s2 < base_reg) | (s2 > limit_reg);
  assign bin        = to_bin(s2);
  assign misalign   = (acc_size == 2'd1 & bin[0]) | (acc_size == 2'd2 & |bin[1:0])
                      | (acc_size == 2'd3);
  assign err_now    = bad_digit | ovf | out_of_win | misalign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      abs_addr   <= '0;
      word_addr  <= '0;
      digit_lane <= '0;
      addr_err   <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        abs_addr   <= s2;
        word_addr  <= bin[BW-1:2];
        digit_lane <= bin[1:0];
        addr_err   <= err_now;
      end
    end
  end

endmodule

// File: rtl/dec_addr_reloc_chk.sv
module dec_addr_reloc_chk #(
  parameter int NDIG = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        acc_size,
  input logic [4*NDIG-1:0] base_reg,
  input logic [4*NDIG-1:0] limit_reg,
  input logic              out_valid,
  input logic [4*NDIG-1:0] abs_addr,
  input logic [1:0]        digit_lane,
  input logic              addr_err
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(abs_addr) && $stable(addr_err) && $stable(digit_lane)));

  a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (addr_err || (abs_addr >= $past(base_reg) && abs_addr <= $past(limit_reg))));

  a_r6_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_size == 2'd2) |=> (addr_err || digit_lane == 2'd0));

  a_r6_byte_align: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_size == 2'd1) |=> (addr_err || !digit_lane[0]));

  a_r6_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_size == 2'd3) |=> addr_err);

endmodule

bind dec_addr_reloc dec_addr_reloc_chk #(.NDIG(NDIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_size(acc_size),
  .base_reg(base_reg), .limit_reg(limit_reg), .out_valid(out_valid),
  .abs_addr(abs_addr), .digit_lane(digit_lane), .addr_err(addr_err)
);

// File: tb/dec_addr_reloc_tb.sv
`timescale 1ns/1ps
module dec_addr_reloc_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] rel_addr, base_reg, limit_reg;
  logic [1:0]  idx_sel, acc_size;
  logic [71:0] idx_mag;
  logic [2:0]  idx_neg;
  logic        out_valid, addr_err;
  logic [23:0] abs_addr;
  logic [17:0] word_addr;
  logic [1:0]  digit_lane;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dec_addr_reloc u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rel_addr(rel_addr),
    .idx_sel(idx_sel), .acc_size(acc_size), .base_reg(base_reg), .limit_reg(limit_reg),
    .idx_mag(idx_mag), .idx_neg(idx_neg), .out_valid(out_valid), .abs_addr(abs_addr),
    .word_addr(word_addr), .digit_lane(digit_lane), .addr_err(addr_err)
  );

  function automatic bit bcd_ok(input logic [23:0] v);
    for (int i = 0; i < 6; i++) if (v[4*i +: 4] > 9) return 0;
    return 1;
  endfunction

  function automatic int bval(input logic [23:0] v);
    int r = 0;
    for (int i = 5; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [23:0] tobcd(input int n);
    logic [23:0] r;
    int x = n;
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_case(input logic [23:0] rel, input logic [23:0] base, input logic [23:0] lim,
                         input logic [1:0] sel, input logic [1:0] sz, input string tag,
                         output bit exp_err);
    bit ok, ovf;
    int s1, s, m;
    ok = bcd_ok(rel) && bcd_ok(base) && bcd_ok(lim);
    m = 0;
    if (sel != 0) begin
      ok = ok && bcd_ok(idx_mag[24*(sel-1) +: 24]);
      m = bval(idx_mag[24*(sel-1) +: 24]);
      if (idx_neg[sel-1]) m = -m;
    end
    s1  = bval(base) + bval(rel);
    s   = s1 + m;
    ovf = (s1 > 999999) || (s > 999999) || (s < 0);
    exp_err = !ok || ovf || s < bval(base) || s > bval(lim) ||
              (sz == 2'd1 && s % 2 != 0) || (sz == 2'd2 && s % 4 != 0) || sz == 2'd3;
    @(negedge clk);
    rel_addr = rel; base_reg = base; limit_reg = lim; idx_sel = sel; acc_size = sz;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(out_valid == 1'b1, {tag, " R10 valid"}, out_valid, 1);
    check(addr_err == exp_err, {tag, " err"}, addr_err, exp_err);
    if (!exp_err) begin
      check(abs_addr == tobcd(s), {tag, " abs"}, abs_addr, tobcd(s));
      check(word_addr == 18'(s / 4), {tag, " R7 word"}, word_addr, s / 4);
      check(digit_lane == 2'(s % 4), {tag, " R7 lane"}, digit_lane, s % 4);
    end
  endtask

  initial begin
    #(300000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit e;
    logic [23:0] bases [3];
    logic [23:0] lims  [3];
    logic [23:0] held;
    rst_n = 1'b0; req_valid = 1'b0; rel_addr = '0; base_reg = '0; limit_reg = '0;
    idx_sel = '0; acc_size = '0; idx_neg = '0;
    idx_mag = {tobcd(17), tobcd(4321), tobcd(250)};
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(abs_addr == 24'h0, "R1 abs in reset", abs_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    bases[0] = tobcd(0);      lims[0] = tobcd(2000);
    bases[1] = tobcd(1000);   lims[1] = tobcd(3500);
    bases[2] = tobcd(123456); lims[2] = tobcd(999999);
    for (int b = 0; b < 3; b++)
      for (int sel = 0; sel < 4; sel++)
        for (int ng = 0; ng < 2; ng++)
          for (int sz = 0; sz < 4; sz++)
            for (int i = 0; i < 40; i++) begin
              idx_neg = ng[0] ? 3'b111 : 3'b000;
              do_case(tobcd(i * 37 + i % 3), bases[b], lims[b], 2'(sel), 2'(sz),
                      sel == 0 ? "R2" : (ng == 1 ? "R4" : "R3"), e);
            end

    idx_neg = 3'b000;
    do_case(tobcd(500), tobcd(1500), tobcd(2000), 2'd0, 2'd0, "R5 at limit", e);
    check(e == 0, "R5 at limit expect", e, 0);
    do_case(tobcd(501), tobcd(1500), tobcd(2000), 2'd0, 2'd0, "R5 past limit", e);
    check(e == 1, "R5 past limit expect", e, 1);
    idx_neg = 3'b001;
    idx_mag[23:0] = tobcd(1);
    do_case(tobcd(0), tobcd(500), tobcd(900), 2'd1, 2'd0, "R5 below base", e);
    check(e == 1, "R5 below base expect", e, 1);
    do_case(tobcd(1), tobcd(500), tobcd(900), 2'd1, 2'd0, "R5 at base", e);
    check(e == 0, "R5 at base expect", e, 0);

    idx_neg = 3'b000;
    do_case(tobcd(7), tobcd(0), tobcd(99), 2'd0, 2'd0, "R6 digit odd", e);
    do_case(tobcd(7), tobcd(0), tobcd(99), 2'd0, 2'd1, "R6 byte odd", e);
    do_case(tobcd(6), tobcd(0), tobcd(99), 2'd0, 2'd2, "R6 word 6", e);
    do_case(tobcd(8), tobcd(0), tobcd(99), 2'd0, 2'd2, "R6 word 8", e);
    do_case(tobcd(8), tobcd(0), tobcd(99), 2'd0, 2'd3, "R6 size 3", e);
    do_case(tobcd(23457), tobcd(100000), tobcd(999999), 2'd0, 2'd0, "R7 split", e);
    check(word_addr == 18'd30864 && digit_lane == 2'd1, "R7 split value",
          {word_addr, digit_lane}, {18'd30864, 2'd1});

    do_case(24'h00000A, tobcd(0), tobcd(999), 2'd0, 2'd0, "R8 rel nibble", e);
    do_case(tobcd(5), 24'h0B0000, tobcd(999999), 2'd0, 2'd0, "R8 base nibble", e);
    do_case(tobcd(5), tobcd(0), 24'h00F000, 2'd0, 2'd0, "R8 limit nibble", e);
    idx_mag[71:48] = 24'hC00000;
    do_case(tobcd(5), tobcd(0), tobcd(999), 2'd3, 2'd0, "R8 sel index nibble", e);
    check(addr_err == 1'b1, "R8 sel index flagged", addr_err, 1);
    do_case(tobcd(5), tobcd(0), tobcd(999), 2'd0, 2'd0, "R8 unselected index", e);
    check(addr_err == 1'b0 && abs_addr == tobcd(5), "R8 unselected ignored", abs_addr, tobcd(5));

    do_case(tobcd(1), tobcd(999999), tobcd(999999), 2'd0, 2'd0, "R9 carry out", e);
    check(addr_err == 1'b1, "R9 carry flagged", addr_err, 1);
    idx_neg = 3'b001;
    idx_mag[23:0] = tobcd(10);
    do_case(tobcd(5), tobcd(0), tobcd(999999), 2'd1, 2'd0, "R9 borrow", e);
    check(addr_err == 1'b1, "R9 borrow flagged", addr_err, 1);

    idx_neg = 3'b000;
    do_case(tobcd(42), tobcd(0), tobcd(999), 2'd0, 2'd0, "R10 base case", e);
    held = abs_addr;
    rel_addr = tobcd(77);
    repeat (2) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10 idle valid", out_valid, 0);
      check(abs_addr == held, "R10 hold abs", abs_addr, held);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule